// File: doc/BRIEF.md
# Reset and Start-up Sequencer

This block is the reset controller of a small microcontroller. It gathers the reset causes of the chip: an asynchronous power-on reset, an external active-low reset pin, a watchdog time-out pulse, and a wake-up request. It also tracks whether the core sits in the low-power halted state, which it learns from a one-cycle pulse sent when the core executes its halt instruction. From these it produces three reset strobes. One clears the program counter and stack pointer. One returns every other unit to its default state: interrupts off, watchdog cleared and restarted, timer/event counter stopped, I/O ports as inputs. One holds the core idle.

Every reset, and every exit from the halted state, opens a start-up window of `SST_CYCLES` system clocks, 1024 by default. This gives the oscillator time to settle. All strobes that are active stay high for the whole window and drop together on one clock edge. A watchdog time-out while halted gives a warm reset: only the program counter and stack pointer are cleared. Two sticky status bits, a time-out flag and a power-down flag, let software tell the reset causes apart. The halt instruction and the watchdog-clear instruction also update these bits.

The reset pin first passes through a `SYNC_STAGES`-deep synchroniser. If several causes arrive in the same cycle, they are taken in this order: pin, then watchdog, then wake-up, then halt, then watchdog-clear.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n` is low, and after it rises, `pcsp_rst`, `periph_rst` and `core_hold` are 1 and both flags are 0. All three strobes fall exactly `SST_CYCLES` clock cycles after `por_n` rises.
- R2: `core_hold` stays high for exactly `SST_CYCLES` cycles after the last triggering event. `pcsp_rst` and `periph_rst` are never high while `core_hold` is low, and they fall on the same edge as `core_hold`.
- R3: The reset pin, taken low outside the halted state, raises all three strobes on the third rising edge after it goes low, because of the two-flop synchroniser. It leaves both flags unchanged. The strobes fall `SST_CYCLES`+2 cycles after the pin returns high.
- R4: The reset pin taken low while halted gives a full reset, sets the time-out flag to 0 and the power-down flag to 1, and ends the halted state.
- R5: A watchdog time-out outside the halted state gives a full reset (all three strobes). It sets the time-out flag to 1 and leaves the power-down flag unchanged.
- R6: A watchdog time-out while halted gives a warm reset. `pcsp_rst` and `core_hold` are high for the window, `periph_rst` stays 0, and both flags become 1.
- R7: A wake-up request while halted raises only `core_hold` for the window. It sets the power-down flag to 1, leaves the time-out flag unchanged, and ends the halted state.
- R8: `halt_exec` outside a window and outside the halted state sets the power-down flag to 1 and the time-out flag to 0 on the next edge, and enters the halted state. During a window it has no effect.
- R9: `clr_wdt` outside a window and outside the halted state clears both flags on the next edge. During a window or while halted it has no effect.
- R10: A triggering event during an open window restarts the count from zero. The scope of the reset may widen, from warm to full, but never narrows.
- R11: A wake-up request outside the halted state has no effect on the strobes or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to `clk` |
| wdt_timeout | input | 1 | One-cycle watchdog time-out pulse |
| wake_req | input | 1 | Wake-up request from the halted state |
| halt_exec | input | 1 | One-cycle pulse: core executed the halt instruction |
| clr_wdt | input | 1 | One-cycle pulse: core executed the watchdog-clear instruction |
| pcsp_rst | output | 1 | Reset strobe for the program counter and stack pointer |
| periph_rst | output | 1 | Reset strobe for all other state |
| core_hold | output | 1 | Holds the core idle during the start-up window |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |

## Verification
The hardest case to reach from the ports is a second event landing inside an open window whose scope it must widen. An example is a warm window, opened by a watchdog time-out while halted, that is hit by a later time-out after the halted state has already ended. The stimulus first halts the core and fires the watchdog. Partway through the warm window it pulses `clr_wdt` and `halt_exec`, and both must leave the flags untouched. Then it fires the watchdog again and checks two things: the window restarts from zero, and `periph_rst` joins it for exactly `SST_CYCLES` cycles.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

   // Request from the cause decoder to the start-up window timer.
   typedef struct packed {
      logic restart;   // open or restart the start-up window
      logic full;      // reset all state
      logic pcsp;      // reset program counter and stack pointer
   } rst_req_t;

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rst_seq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shift_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) shift_q <= {STAGES{RST_VAL}};
      else         shift_q <= {shift_q[STAGES-2:0], d};
   end

   assign q = shift_q[STAGES-1];

endmodule

// File: rtl/rst_seq_cause.sv
module rst_seq_cause
   import rst_seq_pkg::*;
(
   input  logic     clk,
   input  logic     por_n,
   input  logic     pin_rst,
   input  logic     wdt_timeout,
   input  logic     wake_req,
   input  logic     halt_exec,
   input  logic     clr_wdt,
   input  logic     win_active,
   output rst_req_t req,
   output logic     to_flag,
   output logic     pd_flag
);

   logic halted_q, to_q, pd_q;
   logic wdt_full, wdt_warm, wake, halt_go, clr;

   // Priority: pin, watchdog, wake-up, halt, watchdog clear.
   always_comb begin
      wdt_full    = wdt_timeout & ~halted_q & ~pin_rst;
      wdt_warm    = wdt_timeout &  halted_q & ~pin_rst;
      wake        = wake_req & halted_q & ~pin_rst & ~wdt_timeout;
      halt_go     = halt_exec & ~halted_q & ~win_active & ~pin_rst & ~wdt_timeout;
      clr         = clr_wdt & ~halted_q & ~win_active & ~pin_rst & ~wdt_timeout
                    & ~halt_exec;
      req.restart = pin_rst | wdt_timeout | wake;
      req.full    = pin_rst | wdt_full;
      req.pcsp    = pin_rst | wdt_timeout;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         halted_q <= 1'b0;
         to_q     <= 1'b0;
         pd_q     <= 1'b0;
      end else if (pin_rst) begin
         if (halted_q) begin
            to_q <= 1'b0;
            pd_q <= 1'b1;
         end
         halted_q <= 1'b0;
      end else if (wdt_full) begin
         to_q <= 1'b1;
      end else if (wdt_warm) begin
         to_q     <= 1'b1;
         pd_q     <= 1'b1;
         halted_q <= 1'b0;
      end else if (wake) begin
         halted_q <= 1'b0;
      end else if (halt_go) begin
         halted_q <= 1'b1;
         to_q     <= 1'b0;
         pd_q     <= 1'b1;
      end else if (clr) begin
         to_q <= 1'b0;
         pd_q <= 1'b0;
      end
   end

   assign to_flag = to_q;
   assign pd_flag = pd_q;

endmodule

// File: rtl/rst_seq_timer.sv
module rst_seq_timer
   import rst_seq_pkg::*;
#(
   parameter int SST_CYCLES = 1024
) (
   input  logic     clk,
   input  logic     por_n,
   input  rst_req_t req,
   output logic     active,
   output logic     full_scope,
   output logic     pcsp_scope
);

   localparam int CNT_W = $clog2(SST_CYCLES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SST_CYCLES - 1);

   if (SST_CYCLES < 2) begin : g_bad_len
      $error("rst_seq_timer: SST_CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic active_q, full_q, pcsp_q, at_end;

   // A power-of-two length ends when the count is all ones; otherwise compare.
   if ((1 << CNT_W) == SST_CYCLES) begin : g_pow2
      assign at_end = &cnt_q;
   end else begin : g_cmp
      assign at_end = (cnt_q == LAST);
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
         full_q   <= 1'b1;
         pcsp_q   <= 1'b1;
      end else if (req.restart) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
         full_q   <= req.full | (active_q & full_q);
         pcsp_q   <= req.pcsp | (active_q & pcsp_q);
      end else if (active_q) begin
         if (at_end) active_q <= 1'b0;
         else        cnt_q    <= cnt_q + 1'b1;
      end
   end

   assign active     = active_q;
   assign full_scope = full_q;
   assign pcsp_scope = pcsp_q;

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
   import rst_seq_pkg::*;
#(
   parameter int SST_CYCLES  = 1024,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic ext_rst_n,
   input  logic wdt_timeout,
   input  logic wake_req,
   input  logic halt_exec,
   input  logic clr_wdt,
   output logic pcsp_rst,
   output logic periph_rst,
   output logic core_hold,
   output logic to_flag,
   output logic pd_flag
);

   logic     pin_n_sync, active, full_scope, pcsp_scope;
   rst_req_t req;

   rst_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
      .clk    (clk),
      .arst_n (por_n),
      .d      (ext_rst_n),
      .q      (pin_n_sync)
   );

   rst_seq_cause u_cause (
      .clk         (clk),
      .por_n       (por_n),
      .pin_rst     (~pin_n_sync),
      .wdt_timeout (wdt_timeout),
      .wake_req    (wake_req),
      .halt_exec   (halt_exec),
      .clr_wdt     (clr_wdt),
      .win_active  (active),
      .req         (req),
      .to_flag     (to_flag),
      .pd_flag     (pd_flag)
   );

   rst_seq_timer #(.SST_CYCLES(SST_CYCLES)) u_timer (
      .clk        (clk),
      .por_n      (por_n),
      .req        (req),
      .active     (active),
      .full_scope (full_scope),
      .pcsp_scope (pcsp_scope)
   );

   assign core_hold  = active;
   assign pcsp_rst   = active & pcsp_scope;
   assign periph_rst = active & full_scope;

endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk #(
   parameter int SST_CYCLES = 1024
) (
   input logic clk,
   input logic por_n,
   input logic pcsp_rst,
   input logic periph_rst,
   input logic core_hold,
   input logic to_flag,
   input logic pd_flag
);

   logic [31:0] run_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)         run_q <= '0;
      else if (core_hold) run_q <= run_q + 1;
      else                run_q <= '0;
   end

   AST_WINDOW_MIN_LEN: assert property (@(posedge clk) disable iff (!por_n)
      $fell(core_hold) |-> (run_q >= 32'(SST_CYCLES)));                     // R2

   AST_STROBES_INSIDE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      (pcsp_rst || periph_rst) |-> core_hold);                              // R2

   AST_FULL_IMPLIES_PCSP: assert property (@(posedge clk) disable iff (!por_n)
      periph_rst |-> pcsp_rst);                                             // R6

   AST_WARM_FLAGS: assert property (@(posedge clk) disable iff (!por_n)
      ($rose(pcsp_rst) && !periph_rst) |-> (to_flag && pd_flag));           // R6

   AST_WAKE_FLAGS: assert property (@(posedge clk) disable iff (!por_n)
      ($rose(core_hold) && !pcsp_rst) |-> (pd_flag && $stable(to_flag)));   // R7

endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk #(.SST_CYCLES(SST_CYCLES)) u_chk (
   .clk        (clk),
   .por_n      (por_n),
   .pcsp_rst   (pcsp_rst),
   .periph_rst (periph_rst),
   .core_hold  (core_hold),
   .to_flag    (to_flag),
   .pd_flag    (pd_flag)
);

// File: tb/test_rst_seq_ctrl.sv
module test_rst_seq_ctrl;

   localparam int SST = 1024;

   logic clk = 1'b0;
   logic por_n = 1'b0, ext_rst_n = 1'b1, wdt_timeout = 1'b0;
   logic wake_req = 1'b0, halt_exec = 1'b0, clr_wdt = 1'b0;
   logic pcsp_rst, periph_rst, core_hold, to_flag, pd_flag;
   int   checks = 0, errors = 0;

   always #2 clk = ~clk;

   rst_seq_ctrl #(.SST_CYCLES(SST), .SYNC_STAGES(2)) i_rst_seq_ctrl (
      .clk, .por_n, .ext_rst_n, .wdt_timeout, .wake_req, .halt_exec, .clr_wdt,
      .pcsp_rst, .periph_rst, .core_hold, .to_flag, .pd_flag
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_flags(input string req, input int to_e, input int pd_e);
      chk(req, "to_flag", int'(to_flag), to_e);
      chk(req, "pd_flag", int'(pd_flag), pd_e);
   endtask

   // Counts samples at falling edges while core_hold is high.
   task automatic measure(output int h, output int p, output int f);
      h = 0; p = 0; f = 0;
      while (core_hold && h < 4 * SST) begin
         h++;
         if (pcsp_rst)   p++;
         if (periph_rst) f++;
         @(negedge clk);
      end
   endtask

   task automatic chk_window(input string req, input int h_e, input int p_e, input int f_e);
      int h, p, f;
      measure(h, p, f);
      chk(req, "core_hold cycles", h, h_e);
      chk(req, "pcsp_rst cycles", p, p_e);
      chk(req, "periph_rst cycles", f, f_e);
      chk("R2", "strobes low after window", int'(pcsp_rst | periph_rst), 0);
   endtask

   task automatic do_halt(input string req);
      halt_exec = 1'b1; @(negedge clk); halt_exec = 1'b0;
      chk_flags(req, 0, 1);
   endtask

   task automatic fire_wdt();
      wdt_timeout = 1'b1; @(negedge clk); wdt_timeout = 1'b0;
   endtask

   task automatic t_por();
      repeat (3) @(negedge clk);
      chk("R1", "strobes during por", int'(pcsp_rst & periph_rst & core_hold), 1);
      por_n = 1'b1;
      chk_flags("R1", 0, 0);
      chk_window("R1", SST, SST, SST);
   endtask

   task automatic t_halt_then_pin();
      do_halt("R8");
      clr_wdt = 1'b1; @(negedge clk); clr_wdt = 1'b0;
      chk_flags("R9", 0, 1);             // clear ignored while halted
      ext_rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R3", "hold before sync", int'(core_hold), 0);
      @(negedge clk);
      chk("R3", "hold after sync", int'(core_hold), 1);
      chk_flags("R4", 0, 1);
      repeat (5) @(negedge clk);
      ext_rst_n = 1'b1;
      chk_window("R4", SST + 2, SST + 2, SST + 2);
   endtask

   task automatic t_wdt_normal();
      fire_wdt();
      chk_flags("R5", 1, 1);
      chk_window("R5", SST, SST, SST);
      clr_wdt = 1'b1; @(negedge clk); clr_wdt = 1'b0;
      chk_flags("R9", 0, 0);
      fire_wdt();
      chk_flags("R5", 1, 0);
      chk_window("R5", SST, SST, SST);
   endtask

   task automatic t_wake_ignored();
      wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
      repeat (3) begin
         chk("R11", "core_hold", int'(core_hold), 0);
         @(negedge clk);
      end
      chk_flags("R11", 1, 0);
   endtask

   task automatic t_wake();
      do_halt("R8");
      wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
      chk_flags("R7", 0, 1);
      chk_window("R7", SST, 0, 0);
      wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
      chk("R7", "halt left after wake", int'(core_hold), 0);
   endtask

   task automatic t_warm();
      do_halt("R8");
      fire_wdt();
      chk_flags("R6", 1, 1);
      chk_window("R6", SST, SST, 0);
   endtask

   task automatic t_restart();
      int seg = 0, pc = 0, pe = 0;
      do_halt("R8");
      fire_wdt();
      for (int i = 0; i < 100; i++) begin
         if (core_hold)  seg++;
         if (pcsp_rst)   pc++;
         if (periph_rst) pe++;
         clr_wdt   = (i == 40);
         halt_exec = (i == 60);
         @(negedge clk);
      end
      chk("R10", "warm segment hold", seg, 100);
      chk("R10", "warm segment pcsp", pc, 100);
      chk("R10", "warm segment periph", pe, 0);
      chk_flags("R9", 1, 1);             // clear and halt ignored in window (R8)
      fire_wdt();
      chk_flags("R10", 1, 1);
      chk_window("R10", SST, SST, SST);
   endtask

   task automatic t_pin_normal();
      ext_rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R3", "full reset", int'(periph_rst & pcsp_rst), 1);
      ext_rst_n = 1'b1;
      chk_flags("R3", 1, 1);
      chk_window("R3", SST + 2, SST + 2, SST + 2);
   endtask

   initial begin
      t_por();
      t_halt_then_pin();
      t_wdt_normal();
      t_wake_ignored();
      t_wake();
      t_warm();
      t_restart();
      t_pin_normal();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule